// File: doc/BRIEF.md
# BF16 Immediate to Double-Precision Expander

This unit serves the execute stage of a floating-point pipeline. It takes one 32-bit instruction word and pulls out a 16-bit immediate that the encoding splits across two fields that do not touch. It then reads that immediate as a brain-float (BF16) value. The immediate becomes the upper half of a single-precision pattern, and the lower 16 bits are zero. That pattern is widened to a 64-bit double-precision value, ready to be written to a floating-point register. The widening is exact for every class of input: zeros, normals, subnormals, infinities and NaNs.

An instruction is accepted when the valid strobe is high and the extended-opcode field matches the configured code. One clock edge later the unit presents the double-precision value, the 5-bit destination register index taken from the same word, and a valid flag. The register-file write, repetition over vectors and full primary-opcode decode are left to the surrounding pipeline. An optional mask lets the primary opcode take part in the match. By default the mask is empty.

Top module: `bf16x_expander`

## Requirements
- R1: Bit positions below use LSB0 numbering. The 16-bit immediate is formed with instr[0] as its most significant bit, followed by instr[20:6] as bits 14..0.
- R2: The destination index res_target equals instr[25:21] of the accepted word.
- R3: An immediate with exponent field imm[14:7] and fraction field imm[6:0] both zero yields a signed zero. res_value[63] equals imm[15] and all other bits are 0. Example: 0x8000 gives 64'h8000000000000000.
- R4: A normal immediate (exponent field 1..254) yields sign imm[15], double exponent imm[14:7]+896, and fraction {imm[6:0], 45 zero bits}. Examples: 0x3F80 gives 64'h3FF0000000000000, 0xBFC0 gives 64'hBFF8000000000000, 0x3FFF gives 64'h3FFFE00000000000.
- R5: Exponent field 255 with fraction 0 yields an infinity of the same sign. 0x7F80 gives 64'h7FF0000000000000 and 0xFF80 gives 64'hFFF0000000000000.
- R6: Exponent field 255 with a non-zero fraction yields exponent 0x7FF, the same sign, and fraction {imm[6:0], 45 zero bits}. No quiet bit is forced. 0x7FC0 gives 64'h7FF8000000000000 and 0x7F81 gives 64'h7FF0200000000000.
- R7: A subnormal immediate (exponent field 0, fraction non-zero) is normalized so that the double value equals fraction × 2^-133 exactly. 0x0001 gives 64'h37A0000000000000 and 0x0040 gives 64'h3800000000000000.
- R8: When in_valid is 1 and instr[5:1] equals XO_CODE, res_valid is 1 after the next rising clock edge, and the result fields hold that word's conversion.
- R9: A rising edge with rst_n low sets res_valid, res_value and res_target to zero.
- R10: After a cycle with no accepted word, res_valid is 0 and res_value and res_target keep their previous contents. This includes a word whose instr[5:1] differs from XO_CODE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Instruction word on instr is present this cycle |
| instr | input | 32 | Instruction word |
| res_valid | output | 1 | Result fields carry a conversion from the previous cycle |
| res_value | output | 64 | Double-precision result |
| res_target | output | 5 | Destination floating-point register index |

## Verification
Every result is due exactly one rising edge after its word is presented. The bench drives a word just after a falling edge and samples all three outputs at the next falling edge, half a period after the capturing edge. Rejected words, whether the strobe is off or the opcode field is wrong, are checked at that same falling edge: the valid flag must be low and the value and index must still hold the last accepted result. Reset is checked one edge after rst_n is sampled low, including while a matching word is being presented.

// File: rtl/bf16x_pkg.sv
// Package bf16x_pkg
// Shared widths and types for the BF16 immediate expander.
// Assumes IEEE-754 binary32 and binary64 layouts.
package bf16x_pkg;

    localparam int INSTR_W   = 32;
    localparam int IMM_W     = 16;
    localparam int REG_IDX_W = 5;
    localparam int XO_W      = 5;
    localparam int MAJOR_W   = 6;

    localparam int SP_EXP_W  = 8;
    localparam int SP_FRAC_W = 23;
    localparam int SP_W      = 1 + SP_EXP_W + SP_FRAC_W;
    localparam int SP_BIAS   = (1 << (SP_EXP_W - 1)) - 1;

    localparam int DP_EXP_W  = 11;
    localparam int DP_FRAC_W = 52;
    localparam int DP_W      = 1 + DP_EXP_W + DP_FRAC_W;
    localparam int DP_BIAS   = (1 << (DP_EXP_W - 1)) - 1;

    localparam int BIAS_DELTA = DP_BIAS - SP_BIAS;
    localparam int FRAC_PAD   = DP_FRAC_W - SP_FRAC_W;
    localparam int IMM_PAD    = SP_W - IMM_W;

    typedef struct packed {
        logic                 sign;
        logic [SP_EXP_W-1:0]  exp;
        logic [SP_FRAC_W-1:0] frac;
    } sp_t;

    typedef struct packed {
        logic                 sign;
        logic [DP_EXP_W-1:0]  exp;
        logic [DP_FRAC_W-1:0] frac;
    } dp_t;

    typedef enum logic [1:0] {
        CLS_ZERO    = 2'd0,
        CLS_SUBNORM = 2'd1,
        CLS_NORMAL  = 2'd2,
        CLS_SPECIAL = 2'd3
    } sp_class_e;

endpackage

// File: rtl/bf16x_field_unpack.sv
// Module bf16x_field_unpack
// Splits a 32-bit instruction word into destination index and split immediate.
// It also reports whether the word is accepted. Field positions are fixed by
// the encoding (MSB0 fields converted to LSB0 below).
// Assumes: the immediate top bit sits in the last bit of the word.
module bf16x_field_unpack
    import bf16x_pkg::*;
#(
    parameter logic [XO_W-1:0]    XO_CODE    = 5'd2,
    parameter logic [MAJOR_W-1:0] MAJOR_CODE = 6'd0,
    parameter logic [MAJOR_W-1:0] MAJOR_MASK = 6'd0
) (
    input  logic [INSTR_W-1:0]   instr,
    output logic [IMM_W-1:0]     imm,
    output logic [REG_IDX_W-1:0] tgt,
    output logic                 hit
);

    localparam int MAJ_HI = INSTR_W - 1;
    localparam int MAJ_LO = INSTR_W - MAJOR_W;
    localparam int TGT_HI = MAJ_LO - 1;
    localparam int TGT_LO = TGT_HI - REG_IDX_W + 1;
    localparam int FI_HI  = TGT_LO - 1;
    localparam int FI_LO  = FI_HI - (IMM_W - 1) + 1;
    localparam int XO_HI  = FI_LO - 1;
    localparam int XO_LO  = XO_HI - XO_W + 1;
    localparam int FI0    = 0;

    logic [MAJOR_W-1:0] major;
    logic [XO_W-1:0]    xo;

    // Slice the fixed fields out of the word.
    always_comb begin
        major = instr[MAJ_HI:MAJ_LO];
        tgt   = instr[TGT_HI:TGT_LO];
        xo    = instr[XO_HI:XO_LO];
        imm   = {instr[FI0], instr[FI_HI:FI_LO]};
    end

    // Accept when the opcode field matches (and the masked primary bits, if any).
    always_comb begin
        hit = (xo == XO_CODE) &&
              ((major & MAJOR_MASK) == (MAJOR_CODE & MAJOR_MASK));
    end

endmodule

// File: rtl/bf16x_lzc.sv
// Module bf16x_lzc
// Counts leading zeros of a W-bit vector. A zero vector yields W.
// Built as a generate chain of per-bit candidates; the highest set bit wins.
module bf16x_lzc #(
    parameter int W     = 23,
    parameter int CNT_W = $clog2(W + 1)
) (
    input  logic [W-1:0]     vec,
    output logic [CNT_W-1:0] cnt
);

    logic [CNT_W-1:0] stage [W+1];

    assign stage[0] = CNT_W'(W);

    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_chain
            // Each bit overrides the lower bits' count when set.
            assign stage[gi+1] = vec[gi] ? CNT_W'(W - 1 - gi) : stage[gi];
        end
    endgenerate

    assign cnt = stage[W];

endmodule

// File: rtl/bf16x_sp_to_dp.sv
// Module bf16x_sp_to_dp
// Exact binary32 to binary64 widening. Subnormals are normalized; NaN payloads
// move to the top of the double fraction with no quieting.
// Purely combinational.
module bf16x_sp_to_dp
    import bf16x_pkg::*;
(
    input  sp_t sp_in,
    output dp_t dp_out
);

    localparam int LZ_W = $clog2(SP_FRAC_W + 1);

    sp_class_e            cls;
    logic [LZ_W-1:0]      lz;
    logic [LZ_W:0]        sub_shift;
    logic [SP_FRAC_W-1:0] sub_frac;
    logic [DP_EXP_W-1:0]  sub_exp;
    logic [DP_EXP_W-1:0]  norm_exp;

    bf16x_lzc #(.W(SP_FRAC_W), .CNT_W(LZ_W)) u_lzc (
        .vec (sp_in.frac),
        .cnt (lz)
    );

    // Classify the single-precision input.
    always_comb begin
        if (sp_in.exp == '0)
            cls = (sp_in.frac == '0) ? CLS_ZERO : CLS_SUBNORM;
        else if (sp_in.exp == '1)
            cls = CLS_SPECIAL;
        else
            cls = CLS_NORMAL;
    end

    // Normalize a subnormal: drop the leading one and rebias the exponent.
    always_comb begin
        sub_shift = {1'b0, lz} + (LZ_W+1)'(1);
        sub_frac  = sp_in.frac << sub_shift;
        sub_exp   = DP_EXP_W'(BIAS_DELTA) - DP_EXP_W'(lz);
        norm_exp  = DP_EXP_W'(sp_in.exp) + DP_EXP_W'(BIAS_DELTA);
    end

    // Assemble the double-precision fields per class.
    always_comb begin
        dp_out.sign = sp_in.sign;
        unique case (cls)
            CLS_ZERO: begin
                dp_out.exp  = '0;
                dp_out.frac = '0;
            end
            CLS_SUBNORM: begin
                dp_out.exp  = sub_exp;
                dp_out.frac = {sub_frac, {FRAC_PAD{1'b0}}};
            end
            CLS_NORMAL: begin
                dp_out.exp  = norm_exp;
                dp_out.frac = {sp_in.frac, {FRAC_PAD{1'b0}}};
            end
            default: begin
                dp_out.exp  = '1;
                dp_out.frac = {sp_in.frac, {FRAC_PAD{1'b0}}};
            end
        endcase
    end

endmodule

// File: rtl/bf16x_expander.sv
// Module bf16x_expander (top)
// Accepts an instruction word, rebuilds its split 16-bit immediate, reads it
// as BF16 and registers the exact double-precision value with the destination
// index one cycle later.
// Assumes a synchronous active-low reset; the outputs hold between accepted words.
module bf16x_expander
    import bf16x_pkg::*;
#(
    parameter logic [XO_W-1:0]    XO_CODE    = 5'd2,
    parameter logic [MAJOR_W-1:0] MAJOR_CODE = 6'd0,
    parameter logic [MAJOR_W-1:0] MAJOR_MASK = 6'd0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [INSTR_W-1:0]   instr,
    output logic                 res_valid,
    output logic [DP_W-1:0]      res_value,
    output logic [REG_IDX_W-1:0] res_target
);

    logic [IMM_W-1:0]     fld_imm;
    logic [REG_IDX_W-1:0] fld_tgt;
    logic                 fld_hit;
    logic                 fire;
    sp_t                  sp_word;
    dp_t                  dp_word;

    bf16x_field_unpack #(
        .XO_CODE    (XO_CODE),
        .MAJOR_CODE (MAJOR_CODE),
        .MAJOR_MASK (MAJOR_MASK)
    ) u_unpack (
        .instr (instr),
        .imm   (fld_imm),
        .tgt   (fld_tgt),
        .hit   (fld_hit)
    );

    // Place the immediate in the upper half of a single-precision word.
    always_comb begin
        sp_word = sp_t'({fld_imm, {IMM_PAD{1'b0}}});
        fire    = in_valid && fld_hit;
    end

    bf16x_sp_to_dp u_widen (
        .sp_in  (sp_word),
        .dp_out (dp_word)
    );

    // Output register: clear on reset, load on an accepted word, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_value  <= '0;
            res_target <= '0;
        end else begin
            res_valid <= fire;
            if (fire) begin
                res_value  <= dp_word;
                res_target <= fld_tgt;
            end
        end
    end

endmodule

// File: rtl/bf16x_expander_chk.sv
// Module bf16x_expander_chk
// Protocol and field checks on bf16x_expander, attached with bind.
module bf16x_expander_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        hit,
    input logic [25:6] instr_hi,
    input logic        fi0,
    input logic        res_valid,
    input logic [63:0] res_value,
    input logic [4:0]  res_target
);

    logic        acc;
    logic [15:0] imm;
    assign acc = in_valid && hit;
    assign imm = {fi0, instr_hi[20:6]};

    // R8: an accepted word produces a valid result one edge later.
    a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> res_valid);

    // R10: no accepted word leaves the valid flag low and the data stable.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> (!res_valid && $stable(res_value) && $stable(res_target)));

    // R2: destination index comes from the word.
    a_r2_target: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> res_target == $past(instr_hi[25:21]));

    // R1: the result sign comes from the last instruction bit.
    a_r1_sign: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> res_value[63] == $past(fi0));

    // R6: all-ones exponent keeps the payload unchanged.
    a_r6_special: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && imm[14:7] == 8'hFF) |=>
            (res_value[62:52] == 11'h7FF && res_value[51:45] == $past(imm[6:0])
             && res_value[44:0] == '0));

    // R9: first edge after reset release shows a cleared valid flag.
    a_r9_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !res_valid);

endmodule

bind bf16x_expander bf16x_expander_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .hit        (fld_hit),
    .instr_hi   (instr[25:6]),
    .fi0        (instr[0]),
    .res_valid  (res_valid),
    .res_value  (res_value),
    .res_target (res_target)
);

// File: tb/sim_bf16x_expander.sv
module sim_bf16x_expander;

    localparam logic [4:0] XO = 5'd2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic        res_valid;
    logic [63:0] res_value;
    logic [4:0]  res_target;

    int n_tests = 0;
    int n_fail  = 0;
    logic [63:0] last_val = '0;
    logic [4:0]  last_tgt = '0;

    always #5 clk = ~clk;

    bf16x_expander #(.XO_CODE(XO)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .res_valid(res_valid), .res_value(res_value), .res_target(res_target)
    );

    // Expected double for a BF16 immediate, from the value it denotes.
    function automatic logic [63:0] ref_dp(input logic [15:0] imm);
        logic        s;
        int          e;
        int          f;
        real         mag;
        logic [63:0] b;
        s = imm[15];
        e = int'(imm[14:7]);
        f = int'(imm[6:0]);
        if (e == 255)
            return {s, 11'h7FF, imm[6:0], 45'b0};
        if (e == 0 && f == 0)
            return {s, 63'b0};
        if (e == 0)
            mag = real'(f) * (2.0 ** (-133));
        else
            mag = (1.0 + real'(f) / 128.0) * (2.0 ** (e - 127));
        b = $realtobits(mag);
        b[63] = s;
        return b;
    endfunction

    function automatic logic [31:0] mk_instr(input logic [15:0] imm,
                                             input logic [4:0] tgt,
                                             input logic [4:0] xo);
        return {6'h3B, tgt, imm[14:0], xo, imm[15]};
    endfunction

    task automatic check(input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present one word for one cycle, then check at the following falling edge.
    task automatic apply(input logic [15:0] imm, input logic [4:0] tgt,
                         input bit good, input string req);
        instr    = mk_instr(imm, tgt, good ? XO : (XO ^ 5'd5));
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        if (good) begin
            last_val = ref_dp(imm);
            last_tgt = tgt;
            check({req, " R8 valid"}, 64'(res_valid), 64'd1);
        end else begin
            check("R10 valid low on opcode mismatch", 64'(res_valid), 64'd0);
        end
        check({req, " value"}, res_value, last_val);
        check("R2 target", 64'(res_target), 64'(last_tgt));
    endtask

    task automatic directed(input logic [15:0] imm, input logic [63:0] lit,
                            input string req);
        check({req, " reference"}, ref_dp(imm), lit);
        apply(imm, imm[4:0], 1'b1, req);
        check({req, " literal"}, res_value, lit);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog R8 actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R9 reset valid", 64'(res_valid), 64'd0);
        check("R9 reset value", res_value, 64'd0);
        check("R9 reset target", 64'(res_target), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        directed(16'h0000, 64'h0000000000000000, "R3 +0");
        directed(16'h8000, 64'h8000000000000000, "R3 -0");
        directed(16'h3F80, 64'h3FF0000000000000, "R4 +1");
        directed(16'hBF80, 64'hBFF0000000000000, "R4 -1");
        directed(16'hBFC0, 64'hBFF8000000000000, "R4 -1.5");
        directed(16'h3FFF, 64'h3FFFE00000000000, "R4 1.99");
        directed(16'h7F80, 64'h7FF0000000000000, "R5 +inf");
        directed(16'hFF80, 64'hFFF0000000000000, "R5 -inf");
        directed(16'h7FC0, 64'h7FF8000000000000, "R6 qnan");
        directed(16'h7F81, 64'h7FF0200000000000, "R6 snan");
        directed(16'h0001, 64'h37A0000000000000, "R7 min sub");
        directed(16'h0040, 64'h3800000000000000, "R7 max sub bit");
        directed(16'h807F, ref_dp(16'h807F), "R7 neg sub");
        directed(16'h8001, {1'b1, 11'h37A, 52'b0}, "R1 top bit");

        // R10: strobe low with a matching word leaves the outputs unchanged.
        instr = mk_instr(16'h4000, 5'd9, XO);
        @(negedge clk);
        check("R10 idle valid", 64'(res_valid), 64'd0);
        check("R10 idle value", res_value, last_val);
        apply(16'h1234, 5'd7, 1'b0, "R10 mismatch");

        for (int i = 0; i < 400; i++) begin
            logic [15:0] r_imm;
            logic [4:0]  r_tgt;
            bit          r_good;
            r_imm  = 16'($urandom);
            r_tgt  = 5'($urandom);
            r_good = ($urandom % 8) != 0;
            apply(r_imm, r_tgt, r_good, "R1 R4 random");
        end

        // R9: reset during an accepted word wins.
        instr    = mk_instr(16'h3F80, 5'd3, XO);
        in_valid = 1'b1;
        rst_n    = 1'b0;
        @(negedge clk);
        check("R9 reset over valid", 64'(res_valid), 64'd0);
        check("R9 reset over value", res_value, 64'd0);
        in_valid = 1'b0;
        rst_n    = 1'b1;
        last_val = '0;
        last_tgt = '0;
        @(negedge clk);
        apply(16'hC2F7, 5'd31, 1'b1, "R4 after reset");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule